// File: doc/BRIEF.md
# Program Counter Fetch Sequencer

This block holds the program counter of a small 8-bit core with separate program and data memories, and it drives the program-memory fetch address. Each time an instruction completes, the counter moves forward by that instruction's length in bytes. A taken jump instead loads a full target address. Decode, arithmetic and the memory arrays sit outside the block. They supply the instruction length, a taken-jump strobe with its target, and a ready qualifier. In return they get the fetch address, a stall flag and a strobe that marks the completion of each instruction.

A sequential advance can carry out of the low address byte into the high byte. The block then spends one extra clock on that instruction. In the first cycle it writes only the low byte. In the second cycle it raises the stall flag and writes the high byte. A jump always loads all sixteen bits in one cycle, so it never pays this cost, even when its target lies in a different page. Crossing an aligned 64-byte block inside a page costs nothing.

Top module: `pcseq_top`

## Requirements
- R1: After reset, fetchAddr is 16'h0000 and stall is 0. With ready low, instDone is also 0.
- R2: In a non-stall cycle with ready low, instDone is 0 and fetchAddr stays the same on the next cycle.
- R3: In a non-stall cycle with ready high, jumpTaken low, and pc+instLen (instLen in 1..3, taken modulo 2^16) having the same bits [15:8] as pc, the block works as follows. instDone is 1 in that cycle, and fetchAddr equals pc+instLen from the next cycle on.
- R4: In a non-stall cycle with ready high, jumpTaken low, and pc+instLen differing from pc in bits [15:8], instDone is 0. On the next cycle fetchAddr[7:0] holds the new low byte and fetchAddr[15:8] holds the old high byte. That next cycle is a stall cycle with stall=1 and instDone=1. After it, fetchAddr holds the full sum. A stall cycle is never followed directly by another stall cycle.
- R5: In a non-stall cycle with ready and jumpTaken both high, instDone is 1 in that cycle and fetchAddr equals jumpTarget on the next cycle. No stall cycle follows, even when the target lies in another 256-byte page.
- R6: A taken jump wins over sequential advance. This includes the case where pc+instLen would cross a page, and in that case no stall follows either.
- R7: During a stall cycle, ready, jumpTaken, jumpTarget and instLen have no effect, and the high byte is still written.
- R8: A sequential advance that wraps past 16'hFFFF to a low address counts as a page crossing and takes the stall cycle.
- R9: A sequential advance across an aligned 64-byte block boundary inside one 256-byte page takes no extra cycle. An example is 16'h003E plus 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| instLen | input | 2 | Length of the current instruction in bytes, 1 to 3 |
| jumpTaken | input | 1 | The current instruction is a taken jump |
| jumpTarget | input | 16 | Jump destination address |
| ready | input | 1 | The current instruction may complete this cycle |
| fetchAddr | output | 16 | Program counter, used as the fetch address |
| stall | output | 1 | High-byte penalty cycle in progress |
| instDone | output | 1 | The current instruction completes this cycle |

## Verification
The following properties are checked in every cycle:
- A stall cycle never lasts more than one clock.
- The high byte is held while the low byte is written.
- The low byte is held during the stall cycle.
- Every jump and every plain advance lands on the right address.
- Completion is withheld when ready is low or when a page is being crossed.

Some behaviour can only be shown by the bench's scenarios, which compare every cycle's outputs against a bench model. This covers whole instruction sequences, where a jump meets a page-crossing length, where the address wraps at the top of memory, how a 64-byte boundary passes inside a page, and the fact that inputs driven during a stall cycle are ignored.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  // Strobes from the sequencing control to the address datapath
  typedef struct packed {
    logic loadJump;  // load full target
    logic loadSeq;   // load full sequential sum
    logic loadLow;   // load low byte of sum, park high byte
    logic loadHigh;  // load parked high byte
  } pcStrobe_t;

  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_CARRY = 1'b1
  } seqState_t;

endpackage

// File: rtl/pcseq_datapath.sv
module pcseq_datapath
  import pcseq_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int PAGE_W = 8,
  parameter int LEN_W  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  pcStrobe_t        strobe,
  input  logic [LEN_W-1:0] instLen,
  input  logic [PC_W-1:0]  jumpTarget,
  output logic [PC_W-1:0]  pcOut,
  output logic             crossPage
);

  localparam int HIGH_W = PC_W - PAGE_W;

  logic [PC_W-1:0]   pcReg;
  logic [HIGH_W-1:0] pendHigh;
  logic [PC_W-1:0]   seqSum;

  assign seqSum    = pcReg + {{(PC_W-LEN_W){1'b0}}, instLen};
  assign crossPage = (seqSum[PC_W-1:PAGE_W] != pcReg[PC_W-1:PAGE_W]);
  assign pcOut     = pcReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcReg    <= '0;
      pendHigh <= '0;
    end else begin
      if (strobe.loadJump) begin
        pcReg <= jumpTarget;
      end else if (strobe.loadSeq) begin
        pcReg <= seqSum;
      end else if (strobe.loadLow) begin
        pcReg[PAGE_W-1:0] <= seqSum[PAGE_W-1:0];
        pendHigh          <= seqSum[PC_W-1:PAGE_W];
      end else if (strobe.loadHigh) begin
        pcReg[PC_W-1:PAGE_W] <= pendHigh;
      end
    end
  end

  AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadJump |=> pcReg == $past(jumpTarget)); // R5

  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadSeq |=> pcReg == $past(pcReg) + PC_W'($past(instLen))); // R3

  AST_HIGH_HELD_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadLow |=> pcReg[PC_W-1:PAGE_W] == $past(pcReg[PC_W-1:PAGE_W])); // R4

  AST_LOW_HELD_STALL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadHigh |=> pcReg[PAGE_W-1:0] == $past(pcReg[PAGE_W-1:0])); // R7

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe)); // R6

endmodule

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
  import pcseq_pkg::*;
#(
  parameter int LEN_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ready,
  input  logic             jumpTaken,
  input  logic [LEN_W-1:0] instLen,
  input  logic             crossPage,
  output pcStrobe_t        strobe,
  output logic             stall,
  output logic             instDone
);

  seqState_t state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    instDone  = 1'b0;
    unique case (state)
      ST_CARRY: begin
        strobe.loadHigh = 1'b1;
        instDone        = 1'b1;
        stateNext       = ST_RUN;
      end
      default: begin
        if (ready) begin
          if (jumpTaken) begin
            strobe.loadJump = 1'b1;
            instDone        = 1'b1;
          end else if (crossPage) begin
            strobe.loadLow = 1'b1;
            stateNext      = ST_CARRY;
          end else begin
            strobe.loadSeq = 1'b1;
            instDone       = 1'b1;
          end
        end
      end
    endcase
  end

  assign stall = (state == ST_CARRY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !stall); // R4

  AST_NO_DONE_ON_CROSS: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && ready && !jumpTaken && crossPage) |-> (!instDone ##1 stall)); // R4

  AST_HOLD_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && !ready) |-> !instDone); // R2

  AST_JUMP_NO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && ready && jumpTaken) |=> !stall); // R6

  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && ready && !jumpTaken) |-> instLen != '0); // R3

endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
  import pcseq_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int PAGE_W = 8,
  parameter int LEN_W  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LEN_W-1:0] instLen,
  input  logic             jumpTaken,
  input  logic [PC_W-1:0]  jumpTarget,
  input  logic             ready,
  output logic [PC_W-1:0]  fetchAddr,
  output logic             stall,
  output logic             instDone
);

  pcStrobe_t strobe;
  logic      crossPage;

  pcseq_ctrl #(.LEN_W(LEN_W)) ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ready     (ready),
    .jumpTaken (jumpTaken),
    .instLen   (instLen),
    .crossPage (crossPage),
    .strobe    (strobe),
    .stall     (stall),
    .instDone  (instDone)
  );

  pcseq_datapath #(.PC_W(PC_W), .PAGE_W(PAGE_W), .LEN_W(LEN_W)) dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .instLen    (instLen),
    .jumpTarget (jumpTarget),
    .pcOut      (fetchAddr),
    .crossPage  (crossPage)
  );

endmodule

// File: tb/pcseq_top_test.sv
module pcseq_top_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  instLen = 2'd1;
  logic        jumpTaken = 1'b0;
  logic [15:0] jumpTarget = '0;
  logic        ready = 1'b0;
  logic [15:0] fetchAddr;
  logic        stall;
  logic        instDone;

  int checks = 0;
  int failures = 0;

  logic [15:0] mPc = '0;
  logic [7:0]  mPend = '0;
  logic        mStall = 1'b0;

  always #2.5 clk = ~clk;

  pcseq_top uut (
    .clk(clk), .rstN(rstN), .instLen(instLen), .jumpTaken(jumpTaken),
    .jumpTarget(jumpTarget), .ready(ready), .fetchAddr(fetchAddr),
    .stall(stall), .instDone(instDone)
  );

  function automatic logic crosses(logic [15:0] pc, logic [1:0] len);
    logic [15:0] s;
    s = pc + {14'd0, len};
    return s[15:8] != pc[15:8];
  endfunction

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic rdy, logic jmp, logic [15:0] tgt, logic [1:0] len);
    string tag;
    logic expDone;
    logic [15:0] sum;
    @(negedge clk);
    ready = rdy; jumpTaken = jmp; jumpTarget = tgt; instLen = len;
    #1;
    sum = mPc + {14'd0, len};
    if (mStall) begin
      tag = (rdy || jmp) ? "R7" : "R4";
      if (mPc[15:8] == 8'hFF && mPend == 8'h00) tag = "R8";
      expDone = 1'b1;
    end else if (!rdy) begin
      tag = "R2"; expDone = 1'b0;
    end else if (jmp) begin
      tag = crosses(mPc, len) ? "R6" : "R5"; expDone = 1'b1;
    end else if (crosses(mPc, len)) begin
      tag = (mPc[15:8] == 8'hFF) ? "R8" : "R4"; expDone = 1'b0;
    end else begin
      tag = (sum[15:6] != mPc[15:6]) ? "R9" : "R3"; expDone = 1'b1;
    end
    check(tag, "fetchAddr", fetchAddr, mPc);
    check(tag, "stall", {15'd0, stall}, {15'd0, mStall});
    check(tag, "instDone", {15'd0, instDone}, {15'd0, expDone});
    if (mStall) begin
      mPc[15:8] = mPend; mStall = 1'b0;
    end else if (rdy && jmp) begin
      mPc = tgt;
    end else if (rdy) begin
      if (crosses(mPc, len)) begin
        mPc[7:0] = sum[7:0]; mPend = sum[15:8]; mStall = 1'b1;
      end else begin
        mPc = sum;
      end
    end
  endtask

  initial begin
    #(5 * 190000);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    #12;
    check("R1", "reset fetchAddr", fetchAddr, 16'h0000);
    check("R1", "reset stall", {15'd0, stall}, 16'd0);
    check("R1", "reset instDone", {15'd0, instDone}, 16'd0);
    @(negedge clk);
    rstN = 1'b1;
    // R1 state after release
    step(1'b0, 1'b0, 16'h0, 2'd1);
    // R3 plain advance of each length
    step(1'b1, 1'b0, 16'h0, 2'd1);
    step(1'b1, 1'b0, 16'h0, 2'd2);
    step(1'b1, 1'b0, 16'h0, 2'd3);
    // R2 hold
    step(1'b0, 1'b1, 16'h1234, 2'd3);
    // R9 64-byte boundary inside a page
    step(1'b1, 1'b1, 16'h003E, 2'd1);
    step(1'b1, 1'b0, 16'h0, 2'd2);
    step(1'b1, 1'b0, 16'h0, 2'd1);
    // R4 page crossing, then stall cycle with inputs active (R7)
    step(1'b1, 1'b1, 16'h00FE, 2'd1);
    step(1'b1, 1'b0, 16'h0, 2'd3);
    step(1'b1, 1'b1, 16'h5555, 2'd2);
    step(1'b1, 1'b0, 16'h0, 2'd1);
    // R5 jump to another page, no stall
    step(1'b1, 1'b1, 16'h20FF, 2'd1);
    step(1'b1, 1'b1, 16'h3000, 2'd1);
    step(1'b1, 1'b0, 16'h0, 2'd1);
    // R6 jump wins where advance would cross
    step(1'b1, 1'b1, 16'h40FF, 2'd1);
    step(1'b1, 1'b1, 16'h4100, 2'd3);
    step(1'b1, 1'b0, 16'h0, 2'd1);
    // R8 wrap at the top of memory, stall with ready low (R7)
    step(1'b1, 1'b1, 16'hFFFE, 2'd1);
    step(1'b1, 1'b0, 16'h0, 2'd3);
    step(1'b0, 1'b0, 16'h0, 2'd1);
    step(1'b1, 1'b0, 16'h0, 2'd1);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic rdy, jmp;
      logic [1:0] len;
      logic [15:0] tgt;
      rdy = ($urandom % 8) != 0;
      jmp = ($urandom % 6) == 0;
      len = 2'(($urandom % 3) + 1);
      tgt = 16'($urandom);
      if ($urandom % 4 == 0) tgt[7:0] = 8'hFD + 8'($urandom % 3);
      step(rdy, jmp, tgt, len);
    end
    step(1'b0, 1'b0, 16'h0, 2'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule